// File: doc/BRIEF.md
# Masked-Write GPIO Bank Controller

This block is a register-mapped general-purpose I/O controller for four banks of pins, 118 pins in all. Each bank holds an output data word, a per-pin direction word and a per-pin output-enable word. It also offers a read-only view of its pin levels, taken through a two-flop synchronizer. A pin's driver turns on only when both its direction bit and its enable bit are set. The driven level is then the stored data bit.

Software can replace a whole bank's output data with a single write. It can also change any subset of pins in one 16-bit half of a bank through a masked-write register. That write carries a protect mask in the upper half-word and new data in the lower half-word, so it needs no read-modify-write sequence. The bus is a plain 32-bit register port: a byte address, a write strobe, write data, and read data that is combinational on the address. One bank is narrower than the others. Its missing bits are not stored, read back as zero and drive no pin.

Top module: `gpio_mask_ctrl`

## Requirements
- R1: After reset, every output data, direction and enable register reads zero, and every pin_out and pin_oe bit is 0.
- R2: A write to 0x40 + 4*b replaces all stored output data bits of bank b. A read of that address returns the stored value.
- R3: A write to the low masked register of bank b (offset 8*b) updates data bits 15:0. Write-data bit 16+i is the protect bit for bank bit i: a 1 leaves the bit unchanged, and a 0 loads write-data bit i.
- R4: A write to the high masked register of bank b (offset 8*b + 4) updates data bits 31:16. Write-data bit 16+i protects bank bit 16+i, and write-data bit i supplies its new value.
- R5: A read of a masked register returns the matching 16-bit half of the bank's output data in bits 15:0, with bits 31:16 zero.
- R6: The direction register of bank b is at 0x204 + 0x40*b and the enable register is at 0x208 + 0x40*b. Both read back what was written.
- R7: For each pin, pin_oe is the AND of its direction bit and its enable bit. pin_out carries the stored data bit.
- R8: Bank 1 is 22 bits wide and banks 0, 2 and 3 are 32 bits wide. In flat pin numbering the banks start at pins 0, 32, 54 and 86. Bank-1 register bits 31:22 read as zero and affect no pin.
- R9: A read of 0x60 + 4*b returns the bank's pin_in levels, delayed by two clock edges. Writes to these addresses change nothing.
- R10: Within the 0x2E8-byte window, reads of addresses not listed above return zero, and writes to them change no register and no pin.
- R11: A register write takes effect on the rising edge where bus_we is high, and pin_out and pin_oe change on that same edge. Without a write, pin_out and pin_oe hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 10 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one write per cycle when high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 118 | Pin levels from the pads, flat numbering |
| pin_out | output | 118 | Output levels toward the pads |
| pin_oe | output | 118 | Per-pin driver enable toward the pads |

## Verification
The bench sends masked writes whose mask mixes protected and open bits in both halves. A design that inverted the mask sense, or wrote the wrong half, would read back a different merged word. It sets direction and enable in patterns that only partly overlap, so a design that used OR, or only one of the two, would show extra or missing enables. It writes all ones into the narrow bank and checks both the truncated readback and the neighbouring bank's pins, which would catch a bank offset mistake. It reads the input registers one edge and two edges after a pin change to catch a wrong synchronizer depth, and it writes to unmapped and read-only addresses to catch decode aliasing.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

    localparam int REG_W  = 32;
    localparam int HALF_W = 16;
    localparam int ADDR_W = 10;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MASK,
        SEL_FULL,
        SEL_INPUT,
        SEL_DIR,
        SEL_OE
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e   sel;
        logic [1:0] bank;
        logic       hi_half;
    } decode_t;

    function automatic int bank_width(int b, int full_w, int narrow_idx, int narrow_w);
        return (b == narrow_idx) ? narrow_w : full_w;
    endfunction

    function automatic int bank_base(int b, int full_w, int narrow_idx, int narrow_w);
        int acc = 0;
        for (int k = 0; k < b; k++) begin
            acc += bank_width(k, full_w, narrow_idx, narrow_w);
        end
        return acc;
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_mask_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output decode_t           dec
);
    always_comb begin
        dec = '{sel: SEL_NONE, bank: 2'd0, hi_half: 1'b0};
        if (addr[1:0] == 2'b00) begin
            if (addr[9:5] == 5'd0) begin
                dec.sel     = SEL_MASK;
                dec.bank    = addr[4:3];
                dec.hi_half = addr[2];
            end else if (addr[9:4] == 6'h04) begin
                dec.sel  = SEL_FULL;
                dec.bank = addr[3:2];
            end else if (addr[9:4] == 6'h06) begin
                dec.sel  = SEL_INPUT;
                dec.bank = addr[3:2];
            end else if (addr[9:8] == 2'b10 && addr[5:0] == 6'h04) begin
                dec.sel  = SEL_DIR;
                dec.bank = addr[7:6];
            end else if (addr[9:8] == 2'b10 && addr[5:0] == 6'h08) begin
                dec.sel  = SEL_OE;
                dec.bank = addr[7:6];
            end
            if (int'(dec.bank) >= NUM_BANKS) begin
                dec.sel = SEL_NONE;
            end
        end
    end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_mask_pkg::*;
#(
    parameter int W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_full,
    input  logic             we_mask,
    input  logic             hi_half,
    input  logic             we_dir,
    input  logic             we_oe,
    input  logic [REG_W-1:0] wdata,
    output logic [W-1:0]     data_q,
    output logic [W-1:0]     dir_q,
    output logic [W-1:0]     oe_q
);
    typedef struct packed {
        logic [W-1:0] dout;
        logic [W-1:0] dir;
        logic [W-1:0] oe;
    } bank_state_t;

    bank_state_t st_d, st_q;

    logic [REG_W-1:0]  cur_wide;
    logic [HALF_W-1:0] keep_mask, new_bits, old_half, merged;
    logic [REG_W-1:0]  masked_wide;

    always_comb begin
        st_d        = st_q;
        cur_wide    = REG_W'(st_q.dout);
        keep_mask   = wdata[REG_W-1:HALF_W];
        new_bits    = wdata[HALF_W-1:0];
        old_half    = hi_half ? cur_wide[REG_W-1:HALF_W] : cur_wide[HALF_W-1:0];
        merged      = (old_half & keep_mask) | (new_bits & ~keep_mask);
        masked_wide = hi_half ? {merged, cur_wide[HALF_W-1:0]}
                              : {cur_wide[REG_W-1:HALF_W], merged};
        if (we_full) st_d.dout = W'(wdata);
        if (we_mask) st_d.dout = W'(masked_wide);
        if (we_dir)  st_d.dir  = W'(wdata);
        if (we_oe)   st_d.oe   = W'(wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_q = st_q.dout;
    assign dir_q  = st_q.dir;
    assign oe_q   = st_q.oe;
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] held;
    } sync_state_t;

    sync_state_t sy_d, sy_q;

    always_comb begin
        sy_d.meta = raw;
        sy_d.held = sy_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign synced = sy_q.held;
endmodule

// File: rtl/gpio_mask_ctrl.sv
module gpio_mask_ctrl
    import gpio_mask_pkg::*;
#(
    parameter int NUM_BANKS  = 4,
    parameter int FULL_W     = 32,
    parameter int NARROW_IDX = 1,
    parameter int NARROW_W   = 22,
    localparam int NUM_PINS  = bank_base(NUM_BANKS, FULL_W, NARROW_IDX, NARROW_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [REG_W-1:0]    bus_wdata,
    output logic [REG_W-1:0]    bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe
);
    decode_t dec;

    logic [REG_W-1:0] data_ext [NUM_BANKS];
    logic [REG_W-1:0] dir_ext  [NUM_BANKS];
    logic [REG_W-1:0] oe_ext   [NUM_BANKS];
    logic [REG_W-1:0] in_ext   [NUM_BANKS];

    gpio_addr_decode #(.NUM_BANKS(NUM_BANKS)) dec_i (
        .addr (bus_addr),
        .dec  (dec)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int BW = bank_width(b, FULL_W, NARROW_IDX, NARROW_W);
        localparam int BB = bank_base(b, FULL_W, NARROW_IDX, NARROW_W);

        logic          hit;
        logic [BW-1:0] data_q, dir_q, oe_q, in_q;

        assign hit = bus_we && (int'(dec.bank) == b);

        gpio_bank_regs #(.W(BW)) regs_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_full (hit && dec.sel == SEL_FULL),
            .we_mask (hit && dec.sel == SEL_MASK),
            .hi_half (dec.hi_half),
            .we_dir  (hit && dec.sel == SEL_DIR),
            .we_oe   (hit && dec.sel == SEL_OE),
            .wdata   (bus_wdata),
            .data_q  (data_q),
            .dir_q   (dir_q),
            .oe_q    (oe_q)
        );

        gpio_in_sync #(.W(BW)) sync_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw    (pin_in[BB +: BW]),
            .synced (in_q)
        );

        assign pin_out[BB +: BW] = data_q;
        assign pin_oe[BB +: BW]  = dir_q & oe_q;

        assign data_ext[b] = REG_W'(data_q);
        assign dir_ext[b]  = REG_W'(dir_q);
        assign oe_ext[b]   = REG_W'(oe_q);
        assign in_ext[b]   = REG_W'(in_q);
    end

    always_comb begin
        bus_rdata = '0;
        case (dec.sel)
            SEL_MASK:  bus_rdata = dec.hi_half
                                 ? {{HALF_W{1'b0}}, data_ext[dec.bank][REG_W-1:HALF_W]}
                                 : {{HALF_W{1'b0}}, data_ext[dec.bank][HALF_W-1:0]};
            SEL_FULL:  bus_rdata = data_ext[dec.bank];
            SEL_INPUT: bus_rdata = in_ext[dec.bank];
            SEL_DIR:   bus_rdata = dir_ext[dec.bank];
            SEL_OE:    bus_rdata = oe_ext[dec.bank];
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_mask_chk.sv
module gpio_mask_chk
    import gpio_mask_pkg::*;
#(
    parameter int NUM_PINS = 118
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_we,
    input logic [REG_W-1:0]    bus_wdata,
    input logic [REG_W-1:0]    bus_rdata,
    input logic [NUM_PINS-1:0] pin_in,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] pin_oe
);
    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R1: drivers stay off while reset is held
    p_reset_off_r1: assert property (@(posedge clk)
        !rst_n |-> (pin_oe == '0 && pin_out == '0));

    // R2: a full write to bank 0 lands on its pins at the next edge
    p_full_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 10'h040) |=> (pin_out[31:0] == $past(bus_wdata)));

    // R3: protected bits of bank 0's low half keep their level
    p_mask_protect_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 10'h000)
        |=> (((pin_out[15:0] ^ $past(pin_out[15:0])) & $past(bus_wdata[31:16])) == 16'h0));

    // R8: narrow bank never reports bits above its width
    p_narrow_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 10'h044) |-> (bus_rdata[31:22] == 10'h0));

    // R9: input view of bank 0 lags pin_in by two edges
    p_input_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 10'h060 && since_rst == 2'd3) |-> (bus_rdata == $past(pin_in[31:0], 2)));

    // R10: the gap between masked and full registers reads zero
    p_gap_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[9:5] == 5'd1) |-> (bus_rdata == '0));

    // R11: with no write, pin outputs hold
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

bind gpio_mask_ctrl gpio_mask_chk #(.NUM_PINS(NUM_PINS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/gpio_mask_ctrl_tb_top.sv
`timescale 1ns/100ps
module gpio_mask_ctrl_tb_top;
    localparam int NP = 118;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [9:0]    bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_mask_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_we    = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, input logic [31:0] exp, input string req);
        bus_addr = a;
        #0.5;
        check(req, bus_rdata, exp);
    endtask

    task automatic t_reset;
        rd(10'h040, 32'h0, "R1 data0");
        rd(10'h2C4, 32'h0, "R1 dir3");
        rd(10'h248, 32'h0, "R1 oe1");
        check("R1 pin_oe", {31'h0, |pin_oe}, 32'h0);
        check("R1 pin_out", {31'h0, |pin_out}, 32'h0);
    endtask

    task automatic t_full;
        wr(10'h040, 32'hA5A5_1234);
        check("R11 pins same edge", pin_out[31:0], 32'hA5A5_1234);
        rd(10'h040, 32'hA5A5_1234, "R2 readback");
        wr(10'h040, 32'h0F0F_F0F0);
        rd(10'h040, 32'h0F0F_F0F0, "R2 replace");
    endtask

    task automatic t_masked;
        wr(10'h048, 32'hFFFF_0000);
        wr(10'h010, 32'h00F0_1234);
        rd(10'h010, 32'h0000_1204, "R5 low half read");
        rd(10'h048, 32'hFFFF_1204, "R3 low merge");
        wr(10'h014, 32'hFF00_0012);
        rd(10'h014, 32'h0000_FF12, "R5 high half read");
        rd(10'h048, 32'hFF12_1204, "R4 high merge");
        check("R8 bank2 pins", pin_out[54 +: 32], 32'hFF12_1204);
    endtask

    task automatic t_drive;
        wr(10'h04C, 32'hFFFF_FFFF);
        wr(10'h2C4, 32'h0000_FF0F);
        check("R7 dir only", pin_oe[86 +: 32], 32'h0);
        wr(10'h2C8, 32'h0F0F_0F0F);
        rd(10'h2C4, 32'h0000_FF0F, "R6 dir read");
        rd(10'h2C8, 32'h0F0F_0F0F, "R6 oe read");
        check("R7 oe and", pin_oe[86 +: 32], 32'h0000_0F0F);
        check("R7 level", pin_out[86 +: 32], 32'hFFFF_FFFF);
    endtask

    task automatic t_narrow;
        wr(10'h044, 32'hFFFF_FFFF);
        rd(10'h044, 32'h003F_FFFF, "R8 narrow read");
        check("R8 bank1 pins", {10'h0, pin_out[32 +: 22]}, 32'h003F_FFFF);
        check("R8 bank2 untouched", pin_out[54 +: 32], 32'hFF12_1204);
        wr(10'h044, 32'h0);
        wr(10'h00C, 32'h0000_FFFF);
        rd(10'h00C, 32'h0000_003F, "R8 narrow high half");
        wr(10'h244, 32'hFFFF_FFFF);
        wr(10'h248, 32'hFFFF_FFFF);
        rd(10'h244, 32'h003F_FFFF, "R8 narrow dir");
        check("R8 bank1 oe", {10'h0, pin_oe[32 +: 22]}, 32'h003F_FFFF);
        check("R8 bank2 oe", pin_oe[54 +: 32], 32'h0);
    endtask

    task automatic t_input;
        @(negedge clk);
        pin_in[54 +: 32] = 32'hC3A5_5A3C;
        rd(10'h068, 32'h0, "R9 zero edges");
        @(negedge clk);
        rd(10'h068, 32'h0, "R9 one edge");
        @(negedge clk);
        rd(10'h068, 32'hC3A5_5A3C, "R9 two edges");
        pin_in[32 +: 22] = 22'h3F_FFFF;
        repeat (2) @(negedge clk);
        rd(10'h064, 32'h003F_FFFF, "R9 narrow input");
        wr(10'h068, 32'h0);
        rd(10'h068, 32'hC3A5_5A3C, "R9 write ignored");
        check("R9 data untouched", pin_out[54 +: 32], 32'hFF12_1204);
    endtask

    task automatic t_unmapped;
        logic [NP-1:0] po, pe;
        po = pin_out;
        pe = pin_oe;
        wr(10'h020, 32'hFFFF_FFFF);
        wr(10'h050, 32'hFFFF_FFFF);
        wr(10'h200, 32'hFFFF_FFFF);
        wr(10'h20C, 32'hFFFF_FFFF);
        wr(10'h2E4, 32'hFFFF_FFFF);
        wr(10'h041, 32'hFFFF_FFFF);
        rd(10'h020, 32'h0, "R10 read 0x20");
        rd(10'h050, 32'h0, "R10 read 0x50");
        rd(10'h200, 32'h0, "R10 read 0x200");
        rd(10'h20C, 32'h0, "R10 read 0x20C");
        rd(10'h2E4, 32'h0, "R10 read 0x2E4");
        check("R10 pin_out kept", {31'h0, pin_out == po}, 32'h1);
        check("R10 pin_oe kept", {31'h0, pin_oe == pe}, 32'h1);
        rd(10'h040, 32'h0F0F_F0F0, "R10 data0 kept");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full();
        t_masked();
        t_drive();
        t_narrow();
        t_input();
        t_unmapped();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule